// File: doc/BRIEF.md
# Flash Status and Write-Enable Controller

This block keeps the status state of a serial flash device: a write-enable latch, flags for a suspended erase and a suspended program, a protection-lockdown flag, a security-ID lock flag and a busy flag. It receives already-decoded commands as a 4-bit code with a valid strobe. Write-type commands go through only when the latch is set and no conflicting state blocks them. The block presents the six flags as one status byte.

An internal busy timer stands in for the program/erase engine. It counts a parameter number of cycles per operation, can be paused by a suspend and continued by a resume, and raises a completion pulse in its last busy cycle. A software reset runs only when the reset-enable command is the command immediately before it. It clears the latch and any suspended operation but leaves both lock flags untouched. Only the asynchronous power-on reset clears the lockdown flag.

Top module: `flash_stat_ctrl`

## Requirements
- R1: Command codes on `cmd_code` are 0 no-op, 1 write-enable, 2 write-disable, 3 program, 4 erase, 5 suspend, 6 resume, 7 protection write, 8 lockdown, 9 security-ID program, 10 security-ID lockout, 11 reset-enable, 12 reset and 13 status read. Codes 14 and 15 act only as "some other command". Status bits are busy at 0, latch at 1, erase-suspended at 2, program-suspended at 3, lockdown at 4 and ID-lock at 5, with bits 7:6 always 0. After power-on reset the byte reads 0x00.
- R2: When idle, write-enable sets the latch and write-disable clears it. Each takes effect in the cycle after the command.
- R3: Program, erase, protection write, lockdown, security-ID program and lockout are accepted only when the latch is 1. A rejected one changes no flag. `cmd_accept` pulses high for one cycle in the cycle after each accepted one.
- R4: An accepted program, erase or security-ID program sets busy for exactly BUSY_CYCLES cycles. `op_done` is high in the last of them, and the latch is 0 once busy falls.
- R5: While busy, every command other than suspend and status read is ignored. In particular, write-disable leaves the latch at 1.
- R6: A suspend in a busy cycle other than the last clears busy and the latch. It sets the erase-suspended flag for an erase, or the program-suspended flag for a program or security-ID program. A resume while suspended and idle restores busy and clears the flag. The busy cycles before and after the suspend add up to BUSY_CYCLES. A suspend in the last busy cycle has no effect.
- R7: While an operation is suspended, program, erase and security-ID program are rejected.
- R8: Protection write needs the latch, is rejected while the lockdown flag is 1, and clears the latch when accepted.
- R9: Lockdown sets status bit 4 and clears the latch. The bit survives software reset and is cleared only by `rst_n`.
- R10: Lockout sets status bit 5 and clears the latch. No command clears the bit. Once it is set, security-ID program is rejected.
- R11: Reset acts only if the previous valid command was reset-enable given while idle. Any other command in between, including no-op, cancels it. When it acts, it clears the latch and any suspended operation, so bits 1 to 3 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 4 | Decoded command code |
| status | output | 8 | Status byte |
| cmd_accept | output | 1 | One-cycle pulse after an accepted write-type command |
| op_done | output | 1 | High in the last busy cycle of an operation |

## Verification
The bench builds the block with BUSY_CYCLES set to 4. With that value, every busy cycle of a program or an erase can be hit with a suspend, including the last one, where the suspend must be ignored. For each suspend point, the bench computes from the cycle index how many busy cycles remain after the resume, so the split timer is checked across its whole range. The short operations also leave room to walk the lock flags, the reset-enable pairing and the power-on clear in the same run.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam logic [3:0] C_NOP     = 4'd0;
  localparam logic [3:0] C_WREN    = 4'd1;
  localparam logic [3:0] C_WRDI    = 4'd2;
  localparam logic [3:0] C_PROG    = 4'd3;
  localparam logic [3:0] C_ERASE   = 4'd4;
  localparam logic [3:0] C_SUSP    = 4'd5;
  localparam logic [3:0] C_RESUME  = 4'd6;
  localparam logic [3:0] C_WRPROT  = 4'd7;
  localparam logic [3:0] C_LOCKDN  = 4'd8;
  localparam logic [3:0] C_IDPROG  = 4'd9;
  localparam logic [3:0] C_IDLOCK  = 4'd10;
  localparam logic [3:0] C_RSTEN   = 4'd11;
  localparam logic [3:0] C_RST     = 4'd12;
  localparam logic [3:0] C_RDSR    = 4'd13;

  typedef enum logic {OPK_PROG = 1'b0, OPK_ERASE = 1'b1} op_kind_e;
endpackage

// File: rtl/fsc_op_timer.sv
module fsc_op_timer
  import fsc_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  op_kind_e start_kind,
  input  logic     pause,
  input  logic     resume,
  input  logic     abort,
  output logic     busy,
  output logic     done,
  output logic     paused,
  output op_kind_e kind
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          paused_q, paused_d;
  op_kind_e      kind_q, kind_d;

  assign busy   = run_q;
  assign done   = run_q && (cnt_q == LAST);
  assign paused = paused_q;
  assign kind   = kind_q;

  always_comb begin
    cnt_d    = cnt_q;
    run_d    = run_q;
    paused_d = paused_q;
    kind_d   = kind_q;
    if (abort) begin
      run_d    = 1'b0;
      paused_d = 1'b0;
    end else if (start) begin
      cnt_d    = LOAD;
      run_d    = 1'b1;
      paused_d = 1'b0;
      kind_d   = start_kind;
    end else if (run_q) begin
      cnt_d = cnt_q - LAST;
      if (done) begin
        run_d = 1'b0;
      end else if (pause) begin
        run_d    = 1'b0;
        paused_d = 1'b1;
      end
    end else if (paused_q && resume) begin
      run_d    = 1'b1;
      paused_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      run_q    <= 1'b0;
      paused_q <= 1'b0;
      kind_q   <= OPK_PROG;
    end else begin
      cnt_q    <= cnt_d;
      run_q    <= run_d;
      paused_q <= paused_d;
      kind_q   <= kind_d;
    end
  end

  p_pause_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pause && !done && !abort && !start) |=> (!run_q && paused_q));
  p_run_xor_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && paused_q));
  p_start_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (run_q && !done));
endmodule

// File: rtl/fsc_rst_arm.sv
module fsc_rst_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic is_rsten,
  input  logic busy,
  output logic armed
);
  logic armed_q, armed_d;

  assign armed = armed_q;

  always_comb begin
    armed_d = armed_q;
    if (cmd_valid) armed_d = is_rsten && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  p_arm_from_rsten_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(cmd_valid && is_rsten));
endmodule

// File: rtl/flash_stat_ctrl.sv
module flash_stat_ctrl
  import fsc_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  output logic [7:0] status,
  output logic       cmd_accept,
  output logic       op_done
);
  logic     wel_q, wel_d, wpld_q, wpld_d, sec_q, sec_d, acc_q, acc_d;
  logic     start, pause, resume, abort;
  op_kind_e start_kind;
  logic     busy, done, paused, armed;
  op_kind_e kind;
  logic     idle, can_start;

  fsc_op_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind),
    .pause(pause), .resume(resume), .abort(abort), .busy(busy),
    .done(done), .paused(paused), .kind(kind)
  );

  fsc_rst_arm i_arm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .is_rsten(cmd_code == C_RSTEN), .busy(busy), .armed(armed)
  );

  assign idle      = !busy;
  assign can_start = idle && !paused && wel_q;

  always_comb begin
    wel_d      = wel_q;
    wpld_d     = wpld_q;
    sec_d      = sec_q;
    acc_d      = 1'b0;
    start      = 1'b0;
    start_kind = OPK_PROG;
    pause      = 1'b0;
    resume     = 1'b0;
    abort      = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_code)
        C_WREN:   if (idle) wel_d = 1'b1;
        C_WRDI:   if (idle) wel_d = 1'b0;
        C_PROG:   if (can_start) begin start = 1'b1; acc_d = 1'b1; end
        C_ERASE:  if (can_start) begin
                    start = 1'b1; start_kind = OPK_ERASE; acc_d = 1'b1;
                  end
        C_IDPROG: if (can_start && !sec_q) begin start = 1'b1; acc_d = 1'b1; end
        C_SUSP:   if (busy && !done) begin pause = 1'b1; wel_d = 1'b0; end
        C_RESUME: if (idle && paused) resume = 1'b1;
        C_WRPROT: if (idle && wel_q && !wpld_q) begin
                    acc_d = 1'b1; wel_d = 1'b0;
                  end
        C_LOCKDN: if (idle && wel_q) begin
                    acc_d = 1'b1; wel_d = 1'b0; wpld_d = 1'b1;
                  end
        C_IDLOCK: if (idle && wel_q) begin
                    acc_d = 1'b1; wel_d = 1'b0; sec_d = 1'b1;
                  end
        C_RST:    if (idle && armed) begin wel_d = 1'b0; abort = 1'b1; end
        default:  ;
      endcase
    end
    if (done) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      wpld_q <= 1'b0;
      sec_q  <= 1'b0;
      acc_q  <= 1'b0;
    end else begin
      wel_q  <= wel_d;
      wpld_q <= wpld_d;
      sec_q  <= sec_d;
      acc_q  <= acc_d;
    end
  end

  assign status = {2'b00, sec_q, wpld_q,
                   paused && (kind == OPK_PROG),
                   paused && (kind == OPK_ERASE),
                   wel_q, busy};
  assign cmd_accept = acc_q;
  assign op_done    = done;

  p_accept_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> $past(wel_q));
  p_done_clears_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !wel_q);
  p_lockdown_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wpld_q |=> wpld_q);
  p_idlock_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q |=> sec_q);
  p_busy_freezes_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !(cmd_valid && cmd_code == C_SUSP)) |=> $stable(wel_q));
endmodule

// File: tb/test_flash_stat_ctrl.sv
module test_flash_stat_ctrl;
  localparam int BC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic [7:0] status;
  logic       cmd_accept, op_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_stat_ctrl #(.BUSY_CYCLES(BC)) i_flash_stat_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .status(status), .cmd_accept(cmd_accept), .op_done(op_done)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] c);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 4'd0;
  endtask

  task automatic run_idle(output int n, output int last_done);
    n = 0;
    last_done = 0;
    while (status[0] && n < 50) begin
      n++;
      if (op_done) last_done = n;
      @(negedge clk);
    end
  endtask

  task automatic power_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int n, ld;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status, 8'h00, "R1 reset status");

    cmd(4'd1); chk(status, 8'h02, "R2 wren sets latch");
    cmd(4'd2); chk(status, 8'h00, "R2 wrdi clears latch");

    // R3: write-type commands without latch are rejected
    for (int c = 3; c <= 10; c++) begin
      if (c == 5 || c == 6) continue;
      cmd(c[3:0]);
      chk(cmd_accept, 0, "R3 rejected accept");
      chk(status, 8'h00, "R3 rejected no effect");
    end

    // R4: program and erase length, done, latch cleared
    for (int k = 0; k < 3; k++) begin
      cmd(4'd1);
      cmd(k == 0 ? 4'd3 : (k == 1 ? 4'd4 : 4'd9));
      chk(cmd_accept, 1, "R3 accept pulse");
      chk(status, 8'h03, "R4 busy with latch");
      run_idle(n, ld);
      chk(n, BC, "R4 busy length");
      chk(ld, BC, "R4 done in last cycle");
      chk(status, 8'h00, "R4 latch cleared at completion");
      chk(cmd_accept, 0, "R3 accept is one cycle");
    end

    // R5: commands ignored while busy
    cmd(4'd1); cmd(4'd3);
    cmd(4'd2); chk(status, 8'h03, "R5 wrdi ignored while busy");
    cmd(4'd8); chk(status, 8'h03, "R5 lockdown ignored while busy");
    run_idle(n, ld);
    chk(n, BC - 2, "R5 remaining busy");

    // R6: suspend at every busy cycle, both kinds
    for (int kd = 0; kd < 2; kd++) begin
      for (int j = 1; j <= BC; j++) begin
        cmd(4'd1);
        cmd(kd == 1 ? 4'd4 : 4'd3);
        repeat (j - 1) @(negedge clk);
        cmd(4'd5);
        if (j == BC) begin
          chk(status, 8'h00, "R6 suspend in last cycle ignored");
        end else begin
          chk(status, kd == 1 ? 8'h04 : 8'h08, "R6 suspended flags");
          if (j == 2) begin
            cmd(4'd1);
            chk(status, kd == 1 ? 8'h06 : 8'h0a, "R6 wren while suspended");
            cmd(kd == 1 ? 4'd3 : 4'd4);
            chk(cmd_accept, 0, "R7 start rejected while suspended");
            chk(status, kd == 1 ? 8'h06 : 8'h0a, "R7 no effect while suspended");
            cmd(4'd2);
          end
          cmd(4'd6);
          chk(status, 8'h01, "R6 resume restores busy");
          run_idle(n, ld);
          chk(n, BC - j, "R6 remaining cycles after resume");
          chk(status, 8'h00, "R6 idle after resumed op");
        end
      end
    end

    // R11: reset pairing
    cmd(4'd1); cmd(4'd11); cmd(4'd12);
    chk(status, 8'h00, "R11 paired reset clears latch");
    cmd(4'd1); cmd(4'd11); cmd(4'd0); cmd(4'd12);
    chk(status, 8'h02, "R11 nop cancels reset enable");
    cmd(4'd11); cmd(4'd13); cmd(4'd12);
    chk(status, 8'h02, "R11 status read cancels reset enable");
    cmd(4'd4); cmd(4'd5);
    chk(status, 8'h04, "R6 erase suspended");
    cmd(4'd11); cmd(4'd12);
    chk(status, 8'h00, "R11 reset drops suspended op");
    cmd(4'd6);
    chk(status, 8'h00, "R11 resume after reset no effect");

    // R8: protection write
    cmd(4'd1); cmd(4'd7);
    chk(cmd_accept, 1, "R8 protection write accepted");
    chk(status, 8'h00, "R8 protection write clears latch");

    // R9: lockdown
    cmd(4'd1); cmd(4'd8);
    chk(cmd_accept, 1, "R9 lockdown accepted");
    chk(status, 8'h10, "R9 lockdown set");
    cmd(4'd1); cmd(4'd7);
    chk(cmd_accept, 0, "R8 protection write rejected under lockdown");
    chk(status, 8'h12, "R8 latch kept when rejected");
    cmd(4'd11); cmd(4'd12);
    chk(status, 8'h10, "R9 lockdown survives soft reset");

    // R10: lockout
    cmd(4'd10);
    chk(status, 8'h10, "R10 lockout without latch rejected");
    cmd(4'd1); cmd(4'd10);
    chk(status, 8'h30, "R10 lockout set");
    cmd(4'd2); cmd(4'd11); cmd(4'd12);
    chk(status, 8'h30, "R10 lockout survives commands");
    cmd(4'd1); cmd(4'd9);
    chk(cmd_accept, 0, "R10 id program rejected after lockout");
    chk(status, 8'h32, "R10 id program no effect");

    // R9: power reset clears lockdown
    power_reset();
    chk(status, 8'h00, "R9 power reset clears lockdown");
    cmd(4'd1); cmd(4'd7);
    chk(cmd_accept, 1, "R8 protection write after power reset");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule